// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block computes the Montgomery product R = A·B·2^(-len·W) mod N for operands that are `len` words of W bits each. The two operands, the odd modulus N and a precomputed modulus coefficient (the value −N⁻¹ mod 2^(len·W)) are written word by word into internal storage while the block is idle. A start pulse then runs the computation on a row of S processing elements. Each element forms a·b + t + c_in and passes its high half on as a carry. The row sweeps the words of the second operand in chunks of S. When S does not divide `len`, the last chunk is filled with zero words.

The computation runs in three accumulation passes and one correction pass. The first pass forms the full product T = A·B. The second forms the quotient Q = T·coefficient, of which only the low `len` words are used. The third adds Q·N into T. The final pass subtracts N from the upper half of the sum word by word and keeps the difference only when it does not borrow. A reduce-only mode skips the first pass and takes T = A, which gives A·2^(-len·W) mod N. The result is read back through a combinational read port after a one-cycle done pulse.

Top module: `mont_mul_core`

## Requirements
- R1: For odd N, A < N, B < N and len_words in 1..MAX_WORDS, after done, words 0..len-1 of the read port hold A·B·2^(-len·W) mod N. Word 0 is the least significant.
- R2: done is high for exactly one cycle per accepted start, with busy low in that cycle. busy is high from the cycle after an accepted start until that done cycle.
- R3: Operand, modulus and coefficient words at index len_words or above have no effect on the result. They are treated as zero, even when a chunk of S words runs past len_words.
- R4: Lengths that are not a multiple of S (for example 1, 2, 3 and 5 with S = 4) give the same correct result as multiples of S.
- R5: With mode_reduce = 1 at start, the result is A·2^(-len·W) mod N, and the contents of the B store have no effect.
- R6: The returned value is always fully reduced (below N), including the boundary case A = B = N−1 with N = 2^(len·W)−1.
- R7: Writes while busy are ignored. The stores keep their contents, so a second start without reloading reproduces the same result.
- R8: A start pulse while busy is ignored, together with its len_words and mode_reduce values.
- R9: A write in the same cycle as an accepted start is stored, and the computation started in that cycle uses it.
- R10: After reset, busy and done are low and the read port returns zero.
- R11: wr_sel selects the store: 0 = operand A, 1 = operand B, 2 = modulus N, 3 = coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation (accepted when idle) |
| mode_reduce | input | 1 | 1: reduce A only, 0: multiply A·B |
| len_words | input | LEN_W | Operand length in words, 1..MAX_WORDS |
| wr_en | input | 1 | Store write enable |
| wr_sel | input | 2 | Store select (R11 encoding) |
| wr_addr | input | ADDR_W | Word index of the write |
| wr_data | input | WORD_W | Write data |
| rd_addr | input | ADDR_W | Result word index |
| rd_data | output | WORD_W | Result word at rd_addr |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions of this block can coincide in one idle cycle: a store write and the acceptance of a start. The bench writes a new least significant word of A in the very cycle that start is raised. It then checks that the result matches a reference computed with the new word, not the old one. The opposite overlap, a start or writes arriving while busy, is provoked in the middle of a run. It is judged by requiring both the running result and a later rerun to match the original operands.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PROD = 3'd1,
        PH_QUOT = 3'd2,
        PH_ACCN = 3'd3,
        PH_SUB  = 3'd4
    } phase_e;

    // R11: store selection codes
    typedef enum logic [1:0] {
        MEM_A    = 2'd0,
        MEM_B    = 2'd1,
        MEM_N    = 2'd2,
        MEM_COEF = 2'd3
    } mem_sel_e;

endpackage

// File: rtl/mm_pe.sv
module mm_pe #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [WORD_W-1:0] t_in,
    input  logic [WORD_W-1:0] c_in,
    output logic [WORD_W-1:0] s_out,
    output logic [WORD_W-1:0] c_out
);
    localparam int FULL_W = 2 * WORD_W;

    logic [FULL_W-1:0] full;

    always_comb begin
        full = ({{WORD_W{1'b0}}, a_in} * {{WORD_W{1'b0}}, b_in})
             + {{WORD_W{1'b0}}, t_in}
             + {{WORD_W{1'b0}}, c_in};
    end

    assign s_out = full[WORD_W-1:0];
    assign c_out = full[FULL_W-1:WORD_W];
endmodule

// File: rtl/mm_array.sv
module mm_array #(
    parameter int WORD_W  = 16,
    parameter int ARRAY_S = 4
) (
    input  logic [WORD_W-1:0]              a_word,
    input  logic [ARRAY_S-1:0][WORD_W-1:0] b_vec,
    input  logic [ARRAY_S-1:0][WORD_W-1:0] t_vec,
    input  logic [WORD_W-1:0]              carry_in,
    output logic [ARRAY_S-1:0][WORD_W-1:0] s_vec,
    output logic [WORD_W-1:0]              carry_out
);
    logic [ARRAY_S:0][WORD_W-1:0] chain;

    assign chain[0] = carry_in;

    for (genvar j = 0; j < ARRAY_S; j++) begin : g_cell
        mm_pe #(.WORD_W(WORD_W)) u_pe (
            .a_in  (a_word),
            .b_in  (b_vec[j]),
            .t_in  (t_vec[j]),
            .c_in  (chain[j]),
            .s_out (s_vec[j]),
            .c_out (chain[j+1])
        );
    end

    assign carry_out = chain[ARRAY_S];
endmodule

// File: rtl/mm_sub_word.sv
module mm_sub_word #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] s_word,
    input  logic [WORD_W-1:0] n_word,
    input  logic              b_in,
    output logic [WORD_W-1:0] d_word,
    output logic              b_out
);
    logic [WORD_W:0] full;

    always_comb begin
        full = {1'b0, s_word} - {1'b0, n_word} - {{WORD_W{1'b0}}, b_in};
    end

    assign d_word = full[WORD_W-1:0];
    assign b_out  = full[WORD_W];
endmodule

// File: rtl/mont_mul_core.sv
module mont_mul_core
    import mm_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ARRAY_S   = 4,
    parameter int MAX_WORDS = 6,
    localparam int LEN_W    = $clog2(MAX_WORDS + 1),
    localparam int ADDR_W   = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_reduce,
    input  logic [LEN_W-1:0]  len_words,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);
    localparam int ACC_WORDS = 2 * MAX_WORDS + ARRAY_S;
    localparam int IDX_W     = $clog2(ACC_WORDS) + 2;

    typedef logic [MAX_WORDS-1:0][WORD_W-1:0] opmem_t;
    typedef logic [ACC_WORDS-1:0][WORD_W-1:0] accmem_t;

    typedef struct packed {
        phase_e            phase;
        logic              reduce;
        logic [LEN_W-1:0]  len;
        logic [IDX_W-1:0]  row;
        logic [IDX_W-1:0]  off;
        logic [WORD_W-1:0] carry;
        logic              borrow;
        logic              take_diff;
        logic              done;
        opmem_t            opa;
        opmem_t            opb;
        opmem_t            modn;
        opmem_t            coef;
        opmem_t            diff;
        accmem_t           prod;
        accmem_t           quot;
    } state_t;

    state_t st_d, st_q;

    // word of an operand store, zero at or past the active length
    function automatic logic [WORD_W-1:0] op_word(input opmem_t arr,
                                                  input logic [IDX_W-1:0] idx,
                                                  input logic [LEN_W-1:0] lim);
        op_word = '0;
        for (int w = 0; w < MAX_WORDS; w++) begin
            if ((IDX_W'(w) == idx) && (IDX_W'(w) < IDX_W'(lim))) begin
                op_word = arr[w];
            end
        end
    endfunction

    function automatic logic [WORD_W-1:0] acc_word(input accmem_t arr,
                                                   input logic [IDX_W-1:0] idx);
        acc_word = '0;
        for (int w = 0; w < ACC_WORDS; w++) begin
            if (IDX_W'(w) == idx) begin
                acc_word = arr[w];
            end
        end
    endfunction

    function automatic phase_e next_pass(input phase_e ph);
        case (ph)
            PH_PROD: next_pass = PH_QUOT;
            PH_QUOT: next_pass = PH_ACCN;
            default: next_pass = PH_SUB;
        endcase
    endfunction

    // array datapath
    logic [WORD_W-1:0]              row_a;
    logic [ARRAY_S-1:0][WORD_W-1:0] b_vec;
    logic [ARRAY_S-1:0][WORD_W-1:0] t_vec;
    logic [ARRAY_S-1:0][WORD_W-1:0] s_vec;
    logic [WORD_W-1:0]              c_out;
    opmem_t                         src_vec;
    accmem_t                        tgt_acc;
    logic [IDX_W-1:0]               acc_base;
    logic [IDX_W-1:0]               top_idx;
    logic                           mac_active;
    logic                           last_chunk;
    logic                           chunk_end;

    // correction datapath
    logic [WORD_W-1:0] s_word;
    logic [WORD_W-1:0] n_word;
    logic [WORD_W-1:0] d_word;
    logic              b_out;

    always_comb begin
        acc_base   = st_q.row + st_q.off;
        top_idx    = IDX_W'({st_q.len, 1'b0});
        mac_active = (st_q.phase == PH_PROD) || (st_q.phase == PH_QUOT) ||
                     (st_q.phase == PH_ACCN);
        last_chunk = (acc_base + IDX_W'(ARRAY_S)) > top_idx;
        chunk_end  = mac_active && last_chunk;

        case (st_q.phase)
            PH_PROD: begin
                row_a   = op_word(st_q.opa, st_q.row, st_q.len);
                src_vec = st_q.opb;
            end
            PH_QUOT: begin
                row_a   = acc_word(st_q.prod, st_q.row);
                src_vec = st_q.coef;
            end
            PH_ACCN: begin
                row_a   = acc_word(st_q.quot, st_q.row);
                src_vec = st_q.modn;
            end
            default: begin
                row_a   = '0;
                src_vec = st_q.opb;
            end
        endcase

        tgt_acc = (st_q.phase == PH_QUOT) ? st_q.quot : st_q.prod;

        for (int j = 0; j < ARRAY_S; j++) begin
            b_vec[j] = op_word(src_vec, st_q.off + IDX_W'(j), st_q.len);
            t_vec[j] = acc_word(tgt_acc, acc_base + IDX_W'(j));
        end

        s_word = acc_word(st_q.prod, IDX_W'(st_q.len) + st_q.row);
        n_word = op_word(st_q.modn, st_q.row, st_q.len);
    end

    mm_array #(.WORD_W(WORD_W), .ARRAY_S(ARRAY_S)) u_array (
        .a_word    (row_a),
        .b_vec     (b_vec),
        .t_vec     (t_vec),
        .carry_in  (st_q.carry),
        .s_vec     (s_vec),
        .carry_out (c_out)
    );

    mm_sub_word #(.WORD_W(WORD_W)) u_sub (
        .s_word (s_word),
        .n_word (n_word),
        .b_in   (st_q.borrow),
        .d_word (d_word),
        .b_out  (b_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        // store writes, only while idle
        if (wr_en && (st_q.phase == PH_IDLE)) begin
            for (int w = 0; w < MAX_WORDS; w++) begin
                if (ADDR_W'(w) == wr_addr) begin
                    case (mem_sel_e'(wr_sel))
                        MEM_A:    st_d.opa[w]  = wr_data;
                        MEM_B:    st_d.opb[w]  = wr_data;
                        MEM_N:    st_d.modn[w] = wr_data;
                        default:  st_d.coef[w] = wr_data;
                    endcase
                end
            end
        end

        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.len       = len_words;
                    st_d.reduce    = mode_reduce;
                    st_d.row       = '0;
                    st_d.off       = '0;
                    st_d.carry     = '0;
                    st_d.borrow    = 1'b0;
                    st_d.take_diff = 1'b0;
                    st_d.prod      = '0;
                    st_d.quot      = '0;
                    if (mode_reduce) begin
                        for (int w = 0; w < MAX_WORDS; w++) begin
                            if (LEN_W'(w) < len_words) begin
                                st_d.prod[w] = st_d.opa[w];
                            end
                        end
                        st_d.phase = PH_QUOT;
                    end else begin
                        st_d.phase = PH_PROD;
                    end
                end
            end

            PH_PROD, PH_QUOT, PH_ACCN: begin
                for (int w = 0; w < ACC_WORDS; w++) begin
                    for (int j = 0; j < ARRAY_S; j++) begin
                        if (IDX_W'(w) == (acc_base + IDX_W'(j))) begin
                            if (st_q.phase == PH_QUOT) begin
                                st_d.quot[w] = s_vec[j];
                            end else begin
                                st_d.prod[w] = s_vec[j];
                            end
                        end
                    end
                end
                if (last_chunk) begin
                    st_d.carry = '0;
                    st_d.off   = '0;
                    if (st_q.row == (IDX_W'(st_q.len) - IDX_W'(1))) begin
                        st_d.row   = '0;
                        st_d.phase = next_pass(st_q.phase);
                    end else begin
                        st_d.row = st_q.row + IDX_W'(1);
                    end
                end else begin
                    st_d.carry = c_out;
                    st_d.off   = st_q.off + IDX_W'(ARRAY_S);
                end
            end

            PH_SUB: begin
                for (int w = 0; w < MAX_WORDS; w++) begin
                    if (IDX_W'(w) == st_q.row) begin
                        st_d.diff[w] = d_word;
                    end
                end
                st_d.borrow = b_out;
                if (st_q.row == IDX_W'(st_q.len)) begin
                    st_d.phase     = PH_IDLE;
                    st_d.row       = '0;
                    st_d.take_diff = ~b_out;
                    st_d.done      = 1'b1;
                end else begin
                    st_d.row = st_q.row + IDX_W'(1);
                end
            end

            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < MAX_WORDS; w++) begin
            if (ADDR_W'(w) == rd_addr) begin
                rd_data = st_q.take_diff ? st_q.diff[w]
                        : acc_word(st_q.prod, IDX_W'(st_q.len) + IDX_W'(w));
            end
        end
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign done = st_q.done;
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
    parameter int WORD_W   = 16,
    parameter int OPS_BITS = 384
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                chunk_end,
    input logic [WORD_W-1:0]   chunk_carry,
    input logic [OPS_BITS-1:0] ops_flat
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    frozen_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ops_flat));

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_end |-> (chunk_carry == '0));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));
endmodule

bind mont_mul_core mm_checker #(
    .WORD_W   (WORD_W),
    .OPS_BITS (4 * MAX_WORDS * WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .chunk_end   (chunk_end),
    .chunk_carry (c_out),
    .ops_flat    ({st_q.opa, st_q.opb, st_q.modn, st_q.coef})
);

// File: tb/mont_mul_core_test.sv
module mont_mul_core_test;
    localparam int W      = 16;
    localparam int S      = 4;
    localparam int MAXW   = 6;
    localparam int LEN_W  = $clog2(MAXW + 1);
    localparam int ADDR_W = $clog2(MAXW);

    typedef logic [255:0] big_t;

    typedef struct packed {
        logic [3:0]  lenw;
        logic        red;
        logic [95:0] a;
        logic [95:0] b;
        logic [95:0] n;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd1, 1'b0, 96'h1234, 96'h0FED, 96'hFFF1},
        '{4'd2, 1'b0, 96'h89AB_CDEF, 96'h1357_9BDF, 96'hC000_0001},
        '{4'd3, 1'b0, 96'h1000_0000_0001, 96'hEEEE_DDDD_CCCC, 96'hF123_4567_89AB},
        '{4'd4, 1'b0, 96'hFFFF_FFFF_FFFF_FFC4, 96'hFFFF_FFFF_FFFF_FFC4, 96'hFFFF_FFFF_FFFF_FFC5},
        '{4'd5, 1'b0, 96'h7FFF_1234_5678_9ABC_DEF0, 96'h3, 96'h8000_0000_0000_0000_0001},
        '{4'd6, 1'b0, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFE, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFE,
                      96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
        '{4'd3, 1'b1, 96'hABCD_0123_4567, 96'hFFFF, 96'hF123_4567_89AB},
        '{4'd6, 1'b1, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFE, 96'h5, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode_reduce = 1'b0;
    logic [LEN_W-1:0]  len_words = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [W-1:0]      wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [W-1:0]      rd_data;
    logic              busy;
    logic              done;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mont_mul_core #(.WORD_W(W), .ARRAY_S(S), .MAX_WORDS(MAXW)) uut (
        .clk, .rst_n, .start, .mode_reduce, .len_words, .wr_en, .wr_sel,
        .wr_addr, .wr_data, .rd_addr, .rd_data, .busy, .done
    );

    function automatic big_t mont_ref(big_t a, big_t b, big_t n, int lenw, bit red);
        big_t x;
        x = red ? (a % n) : ((a * b) % n);
        for (int i = 0; i < lenw * W; i++) begin
            if (x[0]) x = (x + n) >> 1;
            else      x = x >> 1;
        end
        return x;
    endfunction

    function automatic big_t coef_of(big_t n, int lenw);
        big_t inv;
        big_t mask;
        inv = n;
        for (int i = 0; i < 8; i++) inv = inv * (big_t'(2) - n * inv);
        mask = (big_t'(1) << (lenw * W)) - big_t'(1);
        return (~inv + big_t'(1)) & mask;
    endfunction

    task automatic chk(input bit ok, input string req, input big_t act, input big_t exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [1:0] sel, input int addr, input logic [W-1:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_addr = ADDR_W'(addr);
        wr_data = data;
    endtask

    // R11: selection codes 0=A 1=B 2=N 3=coefficient; R3: junk above len
    task automatic load_store(input logic [1:0] sel, input big_t v, input int lenw);
        for (int w = 0; w < MAXW; w++) begin
            put_word(sel, w, (w < lenw) ? v[W*w +: W] : (16'hA5C3 ^ W'(w)));
        end
    endtask

    task automatic load_all(input int lenw, input big_t a, input big_t b, input big_t n);
        load_store(2'd0, a, lenw);
        load_store(2'd1, b, lenw);
        load_store(2'd2, n, lenw);
        load_store(2'd3, coef_of(n, lenw), lenw);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic launch(input int lenw, input bit red);
        @(negedge clk);
        start       = 1'b1;
        len_words   = LEN_W'(lenw);
        mode_reduce = red;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (1) begin
            @(posedge clk);
            #1;
            if (done) break;
            n++;
            if (n > 5000) begin
                chk(1'b0, "R2 done timeout", big_t'(n), big_t'(0));
                return;
            end
        end
        chk(busy == 1'b0, "R2 busy low with done", big_t'(busy), big_t'(0));
        @(posedge clk);
        #1;
        chk(done == 1'b0, "R2 done one cycle", big_t'(done), big_t'(0));
    endtask

    task automatic read_result(input int lenw, output big_t r);
        r = '0;
        for (int w = 0; w < lenw; w++) begin
            @(negedge clk);
            rd_addr = ADDR_W'(w);
            #1;
            r[W*w +: W] = rd_data;
        end
    endtask

    task automatic run_case(input int lenw, input bit red, input big_t a, input big_t b,
                            input big_t n, input string req);
        big_t got;
        big_t exp;
        load_all(lenw, a, b, n);
        launch(lenw, red);
        wait_done();
        read_result(lenw, got);
        exp = mont_ref(a, b, n, lenw, red);
        chk(got == exp, req, got, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                total++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    initial begin
        big_t got;
        big_t exp;
        big_t a;
        big_t b;
        big_t n;
        big_t mask;
        int   lenw;

        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        chk(busy == 1'b0, "R10 busy after reset", big_t'(busy), big_t'(0));
        chk(done == 1'b0, "R10 done after reset", big_t'(done), big_t'(0));
        chk(rd_data == '0, "R10 rd_data after reset", big_t'(rd_data), big_t'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R3 R4 R5 R6 R11: vector table
        for (int i = 0; i < 8; i++) begin
            run_case(int'(VECS[i].lenw), VECS[i].red, big_t'(VECS[i].a), big_t'(VECS[i].b),
                     big_t'(VECS[i].n),
                     VECS[i].red ? "R5 reduce-only table vector" :
                     "R1 R3 R4 R6 R11 table vector");
        end

        // R1 R4: random operands, odd moduli
        for (int i = 0; i < 10; i++) begin
            lenw = 1 + int'($urandom % MAXW);
            mask = (big_t'(1) << (lenw * W)) - big_t'(1);
            n = (big_t'({$urandom, $urandom, $urandom}) & mask) | big_t'(1)
                | (big_t'(1) << (lenw * W - 1));
            a = big_t'({$urandom, $urandom, $urandom}) % n;
            b = big_t'({$urandom, $urandom, $urandom}) % n;
            run_case(lenw, 1'b0, a, b, n, "R1 R4 random multiply");
        end

        // R6: zero operand gives zero
        run_case(2, 1'b0, big_t'(0), big_t'(32'h1234_5678), big_t'(32'hFFFF_FFFB), "R6 zero operand");

        // R7: writes while busy ignored, rerun reproduces
        a = big_t'(64'h0123_4567_89AB_CDEF);
        b = big_t'(64'h0FED_CBA9_8765_4321);
        n = big_t'(64'hE000_0000_0000_0123);
        exp = mont_ref(a, b, n, 4, 1'b0);
        load_all(4, a, b, n);
        launch(4, 1'b0);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_sel  = 2'(c);
            wr_addr = ADDR_W'(c % MAXW);
            wr_data = 16'hDEAD;
        end
        @(negedge clk);
        wr_en = 1'b0;
        wait_done();
        read_result(4, got);
        chk(got == exp, "R7 writes during busy", got, exp);
        launch(4, 1'b0);
        wait_done();
        read_result(4, got);
        chk(got == exp, "R7 rerun without reload", got, exp);

        // R8: start while busy ignored
        launch(4, 1'b0);
        repeat (3) @(negedge clk);
        start       = 1'b1;
        mode_reduce = 1'b1;
        len_words   = LEN_W'(2);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        read_result(4, got);
        chk(got == exp, "R8 start while busy", got, exp);

        // R9: write in the start cycle is used
        a = big_t'(48'h0000_1111_2222);
        b = big_t'(48'h3333_4444_5555);
        n = big_t'(48'hF123_4567_89AB);
        load_all(3, a, b, n);
        @(negedge clk);
        start       = 1'b1;
        len_words   = LEN_W'(3);
        mode_reduce = 1'b0;
        wr_en       = 1'b1;
        wr_sel      = 2'd0;
        wr_addr     = '0;
        wr_data     = 16'h0777;
        @(negedge clk);
        start = 1'b0;
        wr_en = 1'b0;
        wait_done();
        read_result(3, got);
        a[15:0] = 16'h0777;
        exp = mont_ref(a, b, n, 3, 1'b0);
        chk(got == exp, "R9 write with start", got, exp);

        // R9 R5: same overlap in reduce-only mode
        load_all(3, a, b, n);
        @(negedge clk);
        start       = 1'b1;
        mode_reduce = 1'b1;
        wr_en       = 1'b1;
        wr_sel      = 2'd0;
        wr_addr     = '0;
        wr_data     = 16'h0999;
        @(negedge clk);
        start = 1'b0;
        wr_en = 1'b0;
        wait_done();
        read_result(3, got);
        a[15:0] = 16'h0999;
        exp = mont_ref(a, b, n, 3, 1'b1);
        chk(got == exp, "R9 R5 write with reduce start", got, exp);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule